// File: doc/BRIEF.md
# Segmented Host Request Assembler

This block sits behind a byte-level SMBus slave on a management-controller host interface. Each block-write transaction arrives as a command code, a length byte and up to one chunk of payload. The block joins the transactions into a single request message of up to `MAX_LEN` bytes. A request may come as one transaction, or as a start segment followed by middle segments and an end segment. Each transaction is checked against its length byte and against the state of the message buffer. Payload is committed only when the transaction is accepted.

When a message is complete, the block reports it to the message processor with a one-cycle pulse. The processor reads the assembled bytes through a random-access read port, and the current length is always visible. One request is not forwarded: the interface capability query (byte 0 = 0x18, byte 1 = 0x57). The block answers that query itself with a short fixed reply. A rejected transaction gives a one-cycle error pulse with a reason code.

Top module: `ssif_req_asm`

## Requirements
- R1: Only the command codes 0x02 (single request), 0x06 (segment start), 0x07 (segment middle) and 0x08 (segment end) are acted on. A transaction with any other code changes nothing and raises no pulse.
- R2: A transaction is rejected with error code 1 in three cases: its length byte is missing, its length byte differs from the number of payload bytes that follow, or its length byte exceeds `CHUNK`. The stored message length does not change.
- R3: A single request or segment start with fewer than 2 payload bytes is rejected with error code 2. An accepted one replaces the buffer, so the message length becomes its payload count.
- R4: A middle or end segment that arrives while the message length is 0 is rejected with error code 3.
- R5: A middle or end segment that would make the total exceed `MAX_LEN` is rejected with error code 4, and the message length becomes 0. A total of exactly `MAX_LEN` is accepted.
- R6: A middle segment with fewer than `CHUNK` payload bytes, including zero, completes the message in the same way as an end segment. A middle segment of exactly `CHUNK` bytes appends its payload and does not complete the message.
- R7: A completed message that is not a capability query raises `req_vld_o` in the cycle after the transaction-end strobe. At that time `msg_len_o` holds its length, and `rd_data_o` returns the byte at `rd_addr_i`.
- R8: A completed message whose first two bytes are 0x18 and 0x57 raises `loc_vld_o` instead of `req_vld_o`. When the message has at least 3 bytes and the low nibble of byte 2 is 0, the reply is 7 bytes: 0x1C, 0x57, 0x00, 0x00, 0x80, 0xFF, 0xFF. The reply is packed with byte 0 in `loc_rsp_o[7:0]`.
- R9: A capability query shorter than 3 bytes gets completion code 0xC7. A capability query whose byte 2 has a non-zero low nibble gets completion code 0xCC. Either error reply is 3 bytes long (0x1C, 0x57, code), and the upper bytes of `loc_rsp_o` are 0.
- R10: `req_vld_o`, `loc_vld_o` and `err_o` are single-cycle pulses, each at most once per transaction. Reset makes the message length 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| txn_start_i | input | 1 | Start-of-transaction strobe |
| byte_vld_i | input | 1 | A write byte is present on byte_i |
| byte_i | input | 8 | Write byte: command, then length, then payload |
| txn_end_i | input | 1 | End-of-transaction strobe; the transaction is evaluated here |
| rd_addr_i | input | LW | Message buffer read address |
| rd_data_o | output | 8 | Message byte at rd_addr_i (0 beyond the buffer) |
| msg_len_o | output | LW | Assembled message length |
| req_vld_o | output | 1 | Completed message is ready for the processor |
| loc_vld_o | output | 1 | Capability reply is valid |
| loc_len_o | output | 3 | Capability reply length (3 or 7) |
| loc_rsp_o | output | 56 | Capability reply bytes, byte 0 in [7:0] |
| err_o | output | 1 | Transaction rejected |
| err_code_o | output | 3 | Reject reason: 1 length, 2 short, 3 empty, 4 overflow |

## Verification
The bench builds the block with its default values, `MAX_LEN` = 255 and `CHUNK` = 32. With these values, a full start segment plus seven full middles reaches the overflow reject. One start plus six full middles plus a 31-byte end lands exactly on the 255-byte limit. The chunk size of 32 allows full-chunk middles that do not complete a message, to be compared with shorter middles that do. A reference model of the buffer is kept as a byte queue and checked against the outputs on every clock.

// File: rtl/ssif_req_pkg.sv
package ssif_req_pkg;
  localparam logic [7:0] CMD_SINGLE = 8'h02;
  localparam logic [7:0] CMD_START  = 8'h06;
  localparam logic [7:0] CMD_MID    = 8'h07;
  localparam logic [7:0] CMD_END    = 8'h08;

  localparam logic [7:0] NETFN_APP_REQ = 8'h18;
  localparam logic [7:0] NETFN_APP_RSP = 8'h1C;
  localparam logic [7:0] CAP_QUERY_CMD = 8'h57;
  localparam logic [7:0] CC_OK         = 8'h00;
  localparam logic [7:0] CC_BAD_LEN    = 8'hC7;
  localparam logic [7:0] CC_BAD_FIELD  = 8'hCC;
  localparam logic [7:0] CAP_FLAGS     = 8'h80;

  typedef enum logic [2:0] {
    ERR_NONE  = 3'd0,
    ERR_LEN   = 3'd1,
    ERR_SHORT = 3'd2,
    ERR_EMPTY = 3'd3,
    ERR_OVF   = 3'd4
  } err_e;
endpackage

// File: rtl/ssif_req_rx.sv
module ssif_req_rx #(
  parameter int CHUNK = 32,
  localparam int CW  = $clog2(CHUNK + 4),
  localparam int NW  = $clog2(CHUNK + 2)
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  txn_start_i,
  input  logic                  byte_vld_i,
  input  logic [7:0]            byte_i,
  input  logic                  txn_end_i,
  output logic                  done_o,
  output logic [7:0]            cmd_o,
  output logic                  mal_o,
  output logic [NW-1:0]         n_o,
  output logic [CHUNK-1:0][7:0] stage_o
);
  localparam logic [CW-1:0] SAT = CW'(CHUNK + 3);

  logic          active_q;
  logic [CW-1:0] cnt_q;
  logic [7:0]    cmd_q, lenf_q;
  logic          take;

  assign take = byte_vld_i && active_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      active_q <= 1'b0;
      cnt_q    <= '0;
      cmd_q    <= '0;
      lenf_q   <= '0;
    end else if (txn_start_i) begin
      active_q <= 1'b1;
      cnt_q    <= '0;
    end else if (txn_end_i) begin
      active_q <= 1'b0;
    end else if (take) begin
      if (cnt_q == CW'(0)) cmd_q  <= byte_i;
      if (cnt_q == CW'(1)) lenf_q <= byte_i;
      if (cnt_q != SAT)    cnt_q  <= cnt_q + CW'(1);
    end
  end

  for (genvar j = 0; j < CHUNK; j++) begin : g_stage
    always_ff @(posedge clk_i) begin
      if (take && !txn_start_i && !txn_end_i && cnt_q == CW'(j + 2))
        stage_o[j] <= byte_i;
    end
  end

  // saturation keeps an over-long payload distinguishable from a legal one
  assign n_o    = (cnt_q < CW'(2)) ? '0 : NW'(cnt_q - CW'(2));
  assign done_o = txn_end_i && active_q && !txn_start_i;
  assign cmd_o  = cmd_q;
  assign mal_o  = (cnt_q < CW'(2)) || (lenf_q > 8'(CHUNK)) || (lenf_q != 8'(n_o));
endmodule

// File: rtl/ssif_req_buf.sv
module ssif_req_buf
  import ssif_req_pkg::*;
#(
  parameter int MAX_LEN = 255,
  parameter int CHUNK   = 32,
  localparam int LW = $clog2(MAX_LEN + 1),
  localparam int NW = $clog2(CHUNK + 2),
  localparam int SW = $clog2(CHUNK)
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  done_i,
  input  logic [7:0]            cmd_i,
  input  logic                  mal_i,
  input  logic [NW-1:0]         n_i,
  input  logic [CHUNK-1:0][7:0] stage_i,
  input  logic [LW-1:0]         rd_addr_i,
  output logic [7:0]            rd_data_o,
  output logic [LW-1:0]         len_o,
  output logic [23:0]           head_o,
  output logic                  pend_o,
  output logic                  err_o,
  output logic [2:0]            err_code_o
);
  logic [7:0]    mem [MAX_LEN];
  logic [LW-1:0] len_q, len_n, base;
  logic [LW:0]   sum;
  logic          commit, send, pend_q, err_q;
  err_e          err_n, code_q;

  assign sum = {1'b0, len_q} + (LW+1)'(n_i);

  always_comb begin
    commit = 1'b0;
    send   = 1'b0;
    base   = '0;
    len_n  = len_q;
    err_n  = ERR_NONE;
    if (done_i) begin
      unique case (cmd_i)
        CMD_SINGLE, CMD_START: begin
          if (mal_i)                    err_n = ERR_LEN;
          else if (n_i < NW'(2))        err_n = ERR_SHORT;
          else begin
            commit = 1'b1;
            len_n  = LW'(n_i);
            send   = (cmd_i == CMD_SINGLE);
          end
        end
        CMD_MID, CMD_END: begin
          if (mal_i)                    err_n = ERR_LEN;
          else if (len_q == '0)         err_n = ERR_EMPTY;
          else if (sum > (LW+1)'(MAX_LEN)) begin
            err_n = ERR_OVF;
            len_n = '0;
          end else begin
            commit = 1'b1;
            base   = len_q;
            len_n  = sum[LW-1:0];
            send   = (cmd_i == CMD_END) || (n_i < NW'(CHUNK));
          end
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      len_q  <= '0;
      pend_q <= 1'b0;
      err_q  <= 1'b0;
      code_q <= ERR_NONE;
    end else begin
      len_q  <= len_n;
      pend_q <= send && (len_n != '0);
      err_q  <= (err_n != ERR_NONE);
      code_q <= err_n;
    end
  end

  // each entry picks its byte from the staged chunk by its offset from base
  for (genvar i = 0; i < MAX_LEN; i++) begin : g_mem
    logic [LW:0] off;
    logic        hit;
    assign off = (LW+1)'(i) - {1'b0, base};
    assign hit = commit && ((LW+1)'(i) >= {1'b0, base}) && (off < (LW+1)'(n_i));
    always_ff @(posedge clk_i) begin
      if (hit) mem[i] <= stage_i[off[SW-1:0]];
    end
  end

  assign rd_data_o  = (rd_addr_i < LW'(MAX_LEN)) ? mem[rd_addr_i] : 8'h00;
  assign head_o     = {mem[2], mem[1], mem[0]};
  assign len_o      = len_q;
  assign pend_o     = pend_q;
  assign err_o      = err_q;
  assign err_code_o = code_q;
endmodule

// File: rtl/ssif_req_cap.sv
module ssif_req_cap
  import ssif_req_pkg::*;
#(
  parameter int MAX_LEN = 255,
  localparam int LW = $clog2(MAX_LEN + 1)
) (
  input  logic [23:0]   head_i,
  input  logic [LW-1:0] len_i,
  output logic          is_cap_o,
  output logic [2:0]    rsp_len_o,
  output logic [55:0]   rsp_o
);
  logic [7:0] cc;

  assign is_cap_o = (head_i[7:0] == NETFN_APP_REQ) && (head_i[15:8] == CAP_QUERY_CMD);

  always_comb begin
    if (len_i < LW'(3))              cc = CC_BAD_LEN;
    else if (head_i[19:16] != 4'h0)  cc = CC_BAD_FIELD;
    else                             cc = CC_OK;
  end

  always_comb begin
    if (cc == CC_OK) begin
      rsp_len_o = 3'd7;
      rsp_o     = {8'hFF, 8'hFF, CAP_FLAGS, 8'h00, cc, CAP_QUERY_CMD, NETFN_APP_RSP};
    end else begin
      rsp_len_o = 3'd3;
      rsp_o     = {32'h0, cc, CAP_QUERY_CMD, NETFN_APP_RSP};
    end
  end
endmodule

// File: rtl/ssif_req_asm.sv
module ssif_req_asm #(
  parameter int MAX_LEN = 255,
  parameter int CHUNK   = 32,
  localparam int LW = $clog2(MAX_LEN + 1),
  localparam int NW = $clog2(CHUNK + 2)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          txn_start_i,
  input  logic          byte_vld_i,
  input  logic [7:0]    byte_i,
  input  logic          txn_end_i,
  input  logic [LW-1:0] rd_addr_i,
  output logic [7:0]    rd_data_o,
  output logic [LW-1:0] msg_len_o,
  output logic          req_vld_o,
  output logic          loc_vld_o,
  output logic [2:0]    loc_len_o,
  output logic [55:0]   loc_rsp_o,
  output logic          err_o,
  output logic [2:0]    err_code_o
);
  logic                  done, mal, pend, is_cap;
  logic [7:0]            cmd;
  logic [NW-1:0]         n;
  logic [CHUNK-1:0][7:0] stage;
  logic [23:0]           head;

  ssif_req_rx #(.CHUNK(CHUNK)) u_rx (
    .clk_i, .rst_ni, .txn_start_i, .byte_vld_i, .byte_i, .txn_end_i,
    .done_o(done), .cmd_o(cmd), .mal_o(mal), .n_o(n), .stage_o(stage)
  );

  ssif_req_buf #(.MAX_LEN(MAX_LEN), .CHUNK(CHUNK)) u_buf (
    .clk_i, .rst_ni, .done_i(done), .cmd_i(cmd), .mal_i(mal), .n_i(n),
    .stage_i(stage), .rd_addr_i, .rd_data_o, .len_o(msg_len_o),
    .head_o(head), .pend_o(pend), .err_o, .err_code_o
  );

  ssif_req_cap #(.MAX_LEN(MAX_LEN)) u_cap (
    .head_i(head), .len_i(msg_len_o), .is_cap_o(is_cap),
    .rsp_len_o(loc_len_o), .rsp_o(loc_rsp_o)
  );

  assign req_vld_o = pend && !is_cap;
  assign loc_vld_o = pend && is_cap;
endmodule

// File: rtl/ssif_req_asm_chk.sv
module ssif_req_asm_chk #(
  parameter int MAX_LEN = 255,
  localparam int LW = $clog2(MAX_LEN + 1)
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic [LW-1:0] msg_len_o,
  input logic          req_vld_o,
  input logic          loc_vld_o,
  input logic [2:0]    loc_len_o,
  input logic          err_o,
  input logic [2:0]    err_code_o
);
  p_err_pulse_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |=> !err_o);
  p_req_pulse_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_vld_o || loc_vld_o) |=> !(req_vld_o || loc_vld_o));
  p_one_dest_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({req_vld_o, loc_vld_o}));
  p_no_overflow_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    msg_len_o <= LW'(MAX_LEN));
  p_ovf_clears_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (err_o && err_code_o == 3'd4) |-> msg_len_o == '0);
  p_err_keeps_len_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (err_o && err_code_o != 3'd4) |-> msg_len_o == $past(msg_len_o));
  p_min_len_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (msg_len_o != '0) |-> msg_len_o >= LW'(2));
  p_reply_len_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    loc_vld_o |-> (loc_len_o == 3'd3 || loc_len_o == 3'd7));
endmodule

bind ssif_req_asm ssif_req_asm_chk #(.MAX_LEN(MAX_LEN)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .msg_len_o(msg_len_o), .req_vld_o(req_vld_o),
  .loc_vld_o(loc_vld_o), .loc_len_o(loc_len_o), .err_o(err_o),
  .err_code_o(err_code_o)
);

// File: tb/ssif_req_asm_bench.sv
module ssif_req_asm_bench;
  localparam int CLK_P = 10;
  localparam int MAXL  = 255;
  localparam int CHK   = 32;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        txn_start = 1'b0, byte_vld = 1'b0, txn_end = 1'b0;
  logic [7:0]  byte_d = '0;
  logic [7:0]  rd_addr = '0;
  logic [7:0]  rd_data, msg_len;
  logic        req_vld, loc_vld, err;
  logic [2:0]  loc_len, err_code;
  logic [55:0] loc_rsp;

  int compared = 0, mismatched = 0;
  bit finished = 0;

  logic [7:0] mbuf[$];
  bit         exp_req, exp_loc, exp_err;
  int         exp_code, exp_llen;
  logic [55:0] exp_rsp;

  always #(CLK_P/2) clk = ~clk;

  ssif_req_asm u_ssif_req_asm (
    .clk_i(clk), .rst_ni(rst_n), .txn_start_i(txn_start), .byte_vld_i(byte_vld),
    .byte_i(byte_d), .txn_end_i(txn_end), .rd_addr_i(rd_addr), .rd_data_o(rd_data),
    .msg_len_o(msg_len), .req_vld_o(req_vld), .loc_vld_o(loc_vld),
    .loc_len_o(loc_len), .loc_rsp_o(loc_rsp), .err_o(err), .err_code_o(err_code)
  );

  task automatic cmp(input string req, input string what, input longint act, input longint exp);
    compared++;
    if (act != exp) begin
      mismatched++;
      $display("FAIL %s %s act=%0h exp=%0h at %0t", req, what, act, exp, $time);
    end
  endtask

  // per-clock comparison against the model, then expectations expire (R10)
  task automatic tick();
    @(negedge clk);
    cmp("R7", "req_vld", req_vld, exp_req);
    cmp("R8", "loc_vld", loc_vld, exp_loc);
    cmp("R2", "err", err, exp_err);
    cmp("R3", "msg_len", msg_len, mbuf.size());
    if (exp_err) cmp("R2", "err_code", err_code, exp_code);
    if (exp_loc) begin
      cmp("R9", "loc_len", loc_len, exp_llen);
      cmp("R8", "loc_rsp", loc_rsp, exp_rsp);
    end
    exp_req = 0; exp_loc = 0; exp_err = 0;
  endtask

  task automatic model(input logic [7:0] cmd, input int lenf, input bit with_len,
                       input logic [7:0] pay[$]);
    int  n = pay.size();
    bit  mal = !with_len || lenf > CHK || lenf != n;
    bit  send = 0;
    logic [7:0] cc;
    case (cmd)
      8'h02, 8'h06: begin
        if (mal) begin exp_err = 1; exp_code = 1; end
        else if (n < 2) begin exp_err = 1; exp_code = 2; end
        else begin mbuf = pay; send = (cmd == 8'h02); end
      end
      8'h07, 8'h08: begin
        if (mal) begin exp_err = 1; exp_code = 1; end
        else if (mbuf.size() == 0) begin exp_err = 1; exp_code = 3; end
        else if (mbuf.size() + n > MAXL) begin exp_err = 1; exp_code = 4; mbuf.delete(); end
        else begin
          foreach (pay[k]) mbuf.push_back(pay[k]);
          send = (cmd == 8'h08) || (n < CHK);
        end
      end
      default: ;
    endcase
    if (send && mbuf.size() != 0) begin
      if (mbuf[0] == 8'h18 && mbuf[1] == 8'h57) begin
        exp_loc = 1;
        if (mbuf.size() < 3) cc = 8'hC7;
        else if (mbuf[2][3:0] != 0) cc = 8'hCC;
        else cc = 8'h00;
        if (cc == 8'h00) begin
          exp_llen = 7; exp_rsp = 56'hFFFF80_0000_571C;
        end else begin
          exp_llen = 3; exp_rsp = {32'h0, cc, 8'h57, 8'h1C};
        end
      end else exp_req = 1;
    end
  endtask

  task automatic txn(input logic [7:0] cmd, input int lenf, input bit with_len,
                     input logic [7:0] pay[$]);
    tick(); txn_start = 1;
    tick(); txn_start = 0;
    byte_vld = 1; byte_d = cmd; tick();
    if (with_len) begin byte_d = 8'(lenf); tick(); end
    foreach (pay[k]) begin byte_d = pay[k]; tick(); end
    byte_vld = 0;
    txn_end = 1; model(cmd, lenf, with_len, pay);
    tick(); txn_end = 0;
    tick();
  endtask

  task automatic seg(input logic [7:0] cmd, input int n, input int seed);
    logic [7:0] p[$];
    for (int k = 0; k < n; k++) p.push_back(8'((seed * 7 + k * 3 + 1) & 8'h7F));
    txn(cmd, n, 1, p);
  endtask

  task automatic check_buf(input string req);
    for (int a = 0; a < mbuf.size(); a++) begin
      rd_addr = 8'(a); #1;
      cmp(req, "rd_data", rd_data, mbuf[a]);
    end
    rd_addr = 8'hFF; #1;
    cmp(req, "rd_data_beyond", rd_data, 0);
  endtask

  initial begin
    #(CLK_P * 150000);
    mismatched++;
    $display("FAIL watchdog act=running exp=finished");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    exp_req = 0; exp_loc = 0; exp_err = 0; exp_code = 0; exp_llen = 0; exp_rsp = '0;
    tick(); tick();
    // R10 reset state
    cmp("R10", "msg_len_reset", msg_len, 0);
    rst_n = 1;
    tick();
    // R4 middle and end into an empty buffer
    seg(8'h07, 4, 1);
    seg(8'h08, 4, 2);
    // R1 R7 single request forwarded with contents
    txn(8'h02, 3, 1, '{8'h2C, 8'h01, 8'hAA});
    check_buf("R7");
    // R3 short single and short start
    seg(8'h02, 1, 3);
    seg(8'h06, 0, 4);
    // R2 mismatch, too long, missing length byte
    txn(8'h02, 4, 1, '{8'h2C, 8'h02, 8'h03});
    seg(8'h06, 33, 5);
    txn(8'h07, 0, 0, '{});
    // R1 unknown code has no effect
    seg(8'h05, 4, 6);
    seg(8'h0A, 1, 7);
    check_buf("R1");
    // R6 full middles continue, short end completes
    seg(8'h06, 32, 8); seg(8'h07, 32, 9); seg(8'h07, 32, 10); seg(8'h08, 5, 11);
    check_buf("R6");
    // R6 short middle completes
    seg(8'h06, 32, 12); seg(8'h07, 10, 13);
    check_buf("R6");
    // R6 zero-length middle completes
    seg(8'h06, 4, 14); seg(8'h07, 0, 15);
    // R5 overflow past the limit clears, then middle is empty
    seg(8'h06, 32, 16);
    for (int s = 0; s < 6; s++) seg(8'h07, 32, 20 + s);
    seg(8'h07, 32, 30);
    seg(8'h07, 3, 31);
    // R5 exact limit accepted
    seg(8'h06, 32, 40);
    for (int s = 0; s < 6; s++) seg(8'h07, 32, 41 + s);
    seg(8'h08, 31, 50);
    check_buf("R5");
    // R8 capability query answered locally
    txn(8'h02, 3, 1, '{8'h18, 8'h57, 8'h00});
    // R9 short query and bad field
    txn(8'h02, 2, 1, '{8'h18, 8'h57});
    txn(8'h02, 3, 1, '{8'h18, 8'h57, 8'h05});
    // R8 query through the segmented path
    txn(8'h06, 2, 1, '{8'h18, 8'h57});
    txn(8'h08, 1, 1, '{8'hF0});
    // R10 reset empties a partial message
    seg(8'h06, 32, 60);
    tick(); rst_n = 0; mbuf.delete();
    tick();
    cmp("R10", "msg_len_after_reset", msg_len, 0);
    rst_n = 1;
    tick();
    seg(8'h08, 2, 61);
    tick();
    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule